// File: doc/BRIEF.md
# Stuck-Bus Release Sequencer for a Two-Wire Serial Controller

This block frees a two-wire serial bus that a target device holds low because it stopped partway through an acknowledge. It does not drive the bus lines itself. Instead it issues a timed series of write and read strobes to the byte engine's control, status and data registers. The engine's own start, repeated-start and stop logic then produces the clock pulses and line transitions. A single start pulse launches the sequence. A mode input, latched at launch, picks one of two recipes.

In the pulse-train recipe, nine passes each clear the engine and open a transfer, then force a repeated start. This makes the engine toggle the clock. A closing stop follows the nine passes. In the guarded recipe, the sequencer opens a transfer and waits for bus-busy. It then samples the arbitration-lost flag, which here serves as the sign that the data line is stuck low. That flag decides which of two short control-register recipes runs. Each status wait has a time limit. An expired wait aborts the run and reports an error together with the done pulse. All delays are counted in clock cycles from a cycles-per-microsecond parameter.

Top module: `bus_unstick_seq`

## Requirements
- R1: After reset, busy, done and err are low, and neither reg_wr nor reg_rd is asserted while idle.
- R2: A start pulse while idle launches a run with its first strobe in the next cycle. A start pulse during a run is ignored, and the mode of the ongoing run is kept.
- R3: Register addresses are 0 = control, 1 = status, 2 = data. Control bits are 0x80 enable, 0x20 master, 0x04 repeated start and 0x02 reserved. With mode_erratum = 0, each of nine passes issues these strobes in order: control 0x00, status 0x00, control 0xA0, data read, control 0xA4, data read.
- R4: In the pulse-train recipe, the strobe after each pass's first data read comes SETTLE_US*CYC_PER_US+1 cycles after that read. Between passes, the next pass's first strobe comes GAP_US*CYC_PER_US+1 cycles after the previous read. After the ninth pass no gap is inserted, and the next strobe follows in the next cycle.
- R5: The pulse-train recipe ends with control 0x80, a data read, a settle wait, then control 0x00. Done follows two cycles after the final write.
- R6: With mode_erratum = 1, the run starts with control 0xA0 and then waits for stat_busy before doing anything else.
- R7: If stat_arb_lost is set after bus-busy is seen, the strobes are control 0x00, 0x22, 0xA2, a wait for bus-busy, a data read, a wait for stat_irq_pend, then control 0x82.
- R8: If stat_arb_lost is clear after bus-busy is seen, the strobes are a data read, a wait for stat_irq_pend, then control 0x80.
- R9: A status wait that sees no flag for POLL_US*CYC_PER_US cycles ends the run with no further strobe. Done and err rise POLL_US*CYC_PER_US+1 cycles after the last strobe.
- R10: Done is a one-cycle pulse, and busy is low in that cycle. Err stays valid until the next launch, which clears it.
- R11: At most one register strobe is asserted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| mode_erratum | input | 1 | 0 selects the pulse-train recipe, 1 selects the guarded recipe |
| stat_busy | input | 1 | Bus-busy flag from the engine status |
| stat_arb_lost | input | 1 | Arbitration-lost flag from the engine status |
| stat_irq_pend | input | 1 | Transfer-complete interrupt flag from the engine status |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | output | 8 | Write data, zero when not writing |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run aborted on a status timeout |

## Verification
The bench records every strobe and compares the full order, values and cycle spacing against a list it builds on its own. This catches a missing or doubled gap after the ninth pass, a settle wait that is one cycle short, and repeated-start values written with the wrong bits. Both guarded branches are run. A design that sampled the arbitration flag in the wrong place, or swapped 0x82 and 0x80, would produce a different strobe list. Two timeout cases check that the run aborts exactly at the limit, with err set and no strobe after it. A start pulse injected mid-run must leave the pulse-train trace unchanged. A later clean run must clear err.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

    typedef enum logic [2:0] {
        OP_WR   = 3'd0,
        OP_RD   = 3'd1,
        OP_WAIT = 3'd2,
        OP_POLL = 3'd3,
        OP_BR   = 3'd4,
        OP_END  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2
    } raddr_e;

    typedef enum logic [1:0] {
        DL_SETTLE = 2'd0,
        DL_GAP    = 2'd1,
        DL_POLL   = 2'd2
    } dly_e;

    // control register bit meanings in the byte engine
    localparam logic [7:0] CB_EN      = 8'h80;
    localparam logic [7:0] CB_MASTER  = 8'h20;
    localparam logic [7:0] CB_RESTART = 8'h04;
    localparam logic [7:0] CB_RSV     = 8'h02;

    localparam int STEP_W = 4;

    typedef struct packed {
        op_e               op;
        raddr_e            addr;
        logic [7:0]        wdata;
        dly_e              dly;
        logic              sel_irq;    // poll target: 1 irq pending, 0 bus busy
        logic              skip_last;  // on final pass jump over the gap step
        logic              loop_back;  // after this step start the next pass
        logic [STEP_W-1:0] target;     // branch target when arb-lost is clear
    } step_t;

endpackage

// File: rtl/bus_unstick_rom.sv
module bus_unstick_rom
    import bus_unstick_pkg::*;
(
    input  logic              mode_erratum,
    input  logic [STEP_W-1:0] step,
    output step_t             cur
);

    always_comb begin
        cur = '0;
        cur.op = OP_END;
        if (!mode_erratum) begin
            case (step)
                4'd0:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = 8'h00; end
                4'd1:  begin cur.op = OP_WR;   cur.addr = RA_STAT; cur.wdata = 8'h00; end
                4'd2:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN | CB_MASTER; end
                4'd3:  begin cur.op = OP_RD;   cur.addr = RA_DATA; end
                4'd4:  begin cur.op = OP_WAIT; cur.dly  = DL_SETTLE; end
                4'd5:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN | CB_MASTER | CB_RESTART; end
                4'd6:  begin cur.op = OP_RD;   cur.addr = RA_DATA; cur.skip_last = 1'b1; end
                4'd7:  begin cur.op = OP_WAIT; cur.dly  = DL_GAP; cur.loop_back = 1'b1; end
                4'd8:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN; end
                4'd9:  begin cur.op = OP_RD;   cur.addr = RA_DATA; end
                4'd10: begin cur.op = OP_WAIT; cur.dly  = DL_SETTLE; end
                4'd11: begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = 8'h00; end
                default: cur.op = OP_END;
            endcase
        end else begin
            case (step)
                4'd0:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN | CB_MASTER; end
                4'd1:  begin cur.op = OP_POLL; cur.dly  = DL_POLL; end
                4'd2:  begin cur.op = OP_BR;   cur.target = 4'd11; end
                4'd3:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = 8'h00; end
                4'd4:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_MASTER | CB_RSV; end
                4'd5:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN | CB_MASTER | CB_RSV; end
                4'd6:  begin cur.op = OP_POLL; cur.dly  = DL_POLL; end
                4'd7:  begin cur.op = OP_RD;   cur.addr = RA_DATA; end
                4'd8:  begin cur.op = OP_POLL; cur.dly  = DL_POLL; cur.sel_irq = 1'b1; end
                4'd9:  begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN | CB_RSV; end
                4'd11: begin cur.op = OP_RD;   cur.addr = RA_DATA; end
                4'd12: begin cur.op = OP_POLL; cur.dly  = DL_POLL; cur.sel_irq = 1'b1; end
                4'd13: begin cur.op = OP_WR;   cur.addr = RA_CTRL; cur.wdata = CB_EN; end
                default: cur.op = OP_END;
            endcase
        end
    end

endmodule

// File: rtl/bus_unstick_timer.sv
module bus_unstick_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == limit - 1'b1);

    // R9: a running window never counts past its limit
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < limit));

endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
    import bus_unstick_pkg::*;
#(
    parameter int CYC_PER_US = 4,
    parameter int PASSES     = 9,
    parameter int SETTLE_US  = 15,
    parameter int GAP_US     = 5,
    parameter int POLL_US    = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mode_erratum,
    input  logic       stat_busy,
    input  logic       stat_arb_lost,
    input  logic       stat_irq_pend,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic [1:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       busy,
    output logic       done,
    output logic       err
);

    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int GAP_CYC    = GAP_US * CYC_PER_US;
    localparam int POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int MAX_A      = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int MAX_CYC    = (MAX_A > POLL_CYC) ? MAX_A : POLL_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam int PASS_W     = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    typedef struct packed {
        logic              run;
        logic              mode;
        logic [STEP_W-1:0] step;
        logic [PASS_W-1:0] pass;
        logic              done;
        logic              err;
    } seq_t;

    seq_t  q, d;
    step_t cur;
    logic  adv, tick, expire;
    logic  [CNT_W-1:0] limit;

    bus_unstick_rom u_rom (
        .mode_erratum (q.mode),
        .step         (q.step),
        .cur          (cur)
    );

    always_comb begin
        case (cur.dly)
            DL_SETTLE: limit = CNT_W'(SETTLE_CYC);
            DL_GAP:    limit = CNT_W'(GAP_CYC);
            default:   limit = CNT_W'(POLL_CYC);
        endcase
    end

    bus_unstick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (adv || !q.run),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    always_comb begin
        d    = q;
        d.done = 1'b0;
        adv  = 1'b0;
        tick = 1'b0;
        if (!q.run) begin
            if (start) begin
                d.run  = 1'b1;
                d.mode = mode_erratum;
                d.step = '0;
                d.pass = '0;
                d.err  = 1'b0;
            end
        end else begin
            case (cur.op)
                OP_WR, OP_RD: begin
                    adv = 1'b1;
                    if (cur.skip_last && q.pass == LAST_PASS) d.step = q.step + 4'd2;
                    else                                      d.step = q.step + 4'd1;
                end
                OP_WAIT: begin
                    tick = 1'b1;
                    if (expire) begin
                        adv = 1'b1;
                        if (cur.loop_back) begin
                            d.step = '0;
                            d.pass = q.pass + 1'b1;
                        end else begin
                            d.step = q.step + 4'd1;
                        end
                    end
                end
                OP_POLL: begin
                    if (cur.sel_irq ? stat_irq_pend : stat_busy) begin
                        adv    = 1'b1;
                        d.step = q.step + 4'd1;
                    end else if (expire) begin
                        d.run  = 1'b0;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        tick = 1'b1;
                    end
                end
                OP_BR: begin
                    adv    = 1'b1;
                    d.step = stat_arb_lost ? q.step + 4'd1 : cur.target;
                end
                default: begin
                    d.run  = 1'b0;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_wr    = q.run && (cur.op == OP_WR);
    assign reg_rd    = q.run && (cur.op == OP_RD);
    assign reg_addr  = (reg_wr || reg_rd) ? cur.addr : 2'd0;
    assign reg_wdata = reg_wr ? cur.wdata : 8'h00;
    assign busy      = q.run;
    assign done      = q.done;
    assign err       = q.err;

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_wr && !reg_rd));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !busy));

    a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.mode));

endmodule

// File: tb/tb_bus_unstick_seq.sv
module tb_bus_unstick_seq;

    localparam int CYC = 4;
    localparam int S   = 15 * CYC;
    localparam int G   = 5 * CYC;
    localparam int P   = 100 * CYC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, mode_erratum = 1'b0;
    logic stat_busy = 1'b0, stat_arb_lost = 1'b0, stat_irq_pend = 1'b0;
    logic reg_wr, reg_rd, busy, done, err;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;

    always #4 clk = ~clk;

    bus_unstick_seq #(.CYC_PER_US(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_erratum(mode_erratum),
        .stat_busy(stat_busy), .stat_arb_lost(stat_arb_lost), .stat_irq_pend(stat_irq_pend),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .done(done), .err(err)
    );

    int errors = 0, checks = 0, cyc = 0;
    int got_n = 0, exp_n = 0;
    int got_k[128], got_a[128], got_d[128], got_c[128];
    int exp_k[128], exp_a[128], exp_d[128], exp_dl[128];
    int done_cnt = 0, done_cyc = 0, start_cyc = 0;
    logic done_err = 1'b0, done_busy = 1'b0, prev_done = 1'b0, wide_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (reg_wr || reg_rd) begin
            if (got_n < 128) begin
                got_k[got_n] = reg_wr ? 0 : 1;
                got_a[got_n] = int'(reg_addr);
                got_d[got_n] = int'(reg_wdata);
                got_c[got_n] = cyc;
            end
            got_n = got_n + 1;
        end
        if (done) begin
            done_cnt  = done_cnt + 1;
            done_cyc  = cyc;
            done_err  = err;
            done_busy = busy;
        end
        if (done && prev_done) wide_done = 1'b1;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int k, input int a, input int dv, input int dl);
        exp_k[exp_n] = k; exp_a[exp_n] = a; exp_d[exp_n] = dv; exp_dl[exp_n] = dl;
        exp_n++;
    endtask

    task automatic launch(input logic m);
        got_n = 0; exp_n = 0;
        @(negedge clk);
        start = 1'b1; mode_erratum = m; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        for (int i = 0; i < 4000 && done_cnt == prev; i++) @(negedge clk);
    endtask

    task automatic compare(input string req, input int done_dl, input logic exp_err);
        int prevc;
        chk(got_n == exp_n, {req, " strobe count"}, got_n, exp_n);
        prevc = start_cyc;
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_k[i] == exp_k[i] && got_a[i] == exp_a[i] && got_d[i] == exp_d[i],
                {req, " strobe kind/addr/data"}, got_k[i]*1000 + got_a[i]*256 + got_d[i],
                exp_k[i]*1000 + exp_a[i]*256 + exp_d[i]);
            chk(got_c[i] - prevc == exp_dl[i], {req, " strobe spacing"}, got_c[i] - prevc, exp_dl[i]);
            prevc = got_c[i];
        end
        chk(done_cyc - prevc == done_dl, {req, " R5 R9 done timing"}, done_cyc - prevc, done_dl);
        chk(done_err == exp_err, {req, " R9 R10 err at done"}, int'(done_err), int'(exp_err));
        chk(!done_busy, "R10 busy low with done", int'(done_busy), 0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !err, "R1 reset outputs", int'({busy, done, err}), 0);
        chk(!reg_wr && !reg_rd, "R1 no strobes idle", int'({reg_wr, reg_rd}), 0);
    endtask

    task automatic t_generic;
        int dc, n_after;
        launch(1'b0);
        for (int p = 0; p < 9; p++) begin
            push(0, 0, 8'h00, (p == 0) ? 1 : G + 1);   // R3
            push(0, 1, 8'h00, 1);
            push(0, 0, 8'hA0, 1);
            push(1, 2, 0, 1);
            push(0, 0, 8'hA4, S + 1);                  // R4 settle
            push(1, 2, 0, 1);
        end
        push(0, 0, 8'h80, 1);                          // R4 no gap after last pass, R5
        push(1, 2, 0, 1);
        push(0, 0, 8'h00, S + 1);
        dc = done_cnt;
        repeat (100) @(negedge clk);
        start = 1'b1; mode_erratum = 1'b1;             // R2 ignored while busy
        @(negedge clk);
        start = 1'b0;
        wait_done(dc);
        compare("R3 R4 R5 R2 generic", 2, 1'b0);
        n_after = got_n;
        repeat (20) @(negedge clk);
        chk(got_n == n_after, "R2 no strobes after done", got_n, n_after);
        chk(done_cnt == dc + 1, "R2 single run", done_cnt, dc + 1);
    endtask

    task automatic t_arb_set;
        int dc = done_cnt;
        stat_busy = 1'b1; stat_arb_lost = 1'b1; stat_irq_pend = 1'b1;
        launch(1'b1);
        push(0, 0, 8'hA0, 1);                          // R6
        push(0, 0, 8'h00, 3);                          // R7
        push(0, 0, 8'h22, 1);
        push(0, 0, 8'hA2, 1);
        push(1, 2, 0, 2);
        push(0, 0, 8'h82, 2);
        wait_done(dc);
        compare("R6 R7 arb set", 2, 1'b0);
    endtask

    task automatic t_arb_clear;
        int dc = done_cnt;
        stat_busy = 1'b1; stat_arb_lost = 1'b0; stat_irq_pend = 1'b1;
        launch(1'b1);
        push(0, 0, 8'hA0, 1);
        push(1, 2, 0, 3);                              // R8
        push(0, 0, 8'h80, 2);
        wait_done(dc);
        compare("R8 arb clear", 2, 1'b0);
    endtask

    task automatic t_busy_timeout;
        int dc = done_cnt;
        stat_busy = 1'b0; stat_arb_lost = 1'b0; stat_irq_pend = 1'b1;
        launch(1'b1);
        push(0, 0, 8'hA0, 1);
        wait_done(dc);
        compare("R9 R6 busy timeout", P + 1, 1'b1);
        @(negedge clk);
        chk(err == 1'b1, "R10 err held after done", int'(err), 1);
    endtask

    task automatic t_irq_timeout;
        int dc = done_cnt;
        stat_busy = 1'b1; stat_arb_lost = 1'b0; stat_irq_pend = 1'b0;
        launch(1'b1);
        push(0, 0, 8'hA0, 1);
        push(1, 2, 0, 3);
        wait_done(dc);
        compare("R9 irq timeout", P + 1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_generic();
        t_arb_set();
        t_arb_clear();
        t_busy_timeout();
        t_irq_timeout();
        t_arb_clear();                                  // R10 err cleared on relaunch
        chk(!wide_done, "R10 done one cycle", int'(wide_done), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule